// File: doc/BRIEF.md
# Clock run-in period monitor

This block times the clock run-in burst that opens a caption data line, so that software can judge whether the burst was picked up cleanly. It watches a sliced, binary video data bit against a system clock. A line-start pulse restarts a line clock counter. When that counter reaches a programmable 11-bit start position, the capture window opens and the block times the gaps between the first five rising edges of the data bit that follow.

The four gaps are reported as 8-bit clock counts, packed two per 16-bit read-only register. All four values are replaced in the same clock, and only when the fifth edge has arrived. If the line ends before that, the old values stay in place and a status bit flags the short capture. After a full capture the block ignores the data input until the next line-start pulse. Software reaches the start position, the two result registers and the status bit through a small select/write/read port.

Top module: `runin_period_mon`

## Requirements
- R1: After reset, select 0 and select 1 read 0x0000, select 2 reads 0x07FF and select 3 reads 0x0000.
- R2: Select 0 returns interval 2 in bits 15:8 and interval 1 in bits 7:0. Select 1 returns interval 4 in bits 15:8 and interval 3 in bits 7:0. Select 2 returns the start position in bits 10:0, with bits 15:11 reading zero. Select 3 returns the incomplete flag in bit 0, with bits 15:1 reading zero.
- R3: A write with select 2 loads the 11-bit start position. Writes with select 0, 1 or 3 have no effect on what any select reads.
- R4: Interval n is the number of system clocks from rising edge n to rising edge n+1 of the data input, for edges 1 to 5 seen after the capture window opens.
- R5: The line counter is cleared by the line-start pulse and advances one per clock. Rising edges that arrive before the counter reaches the start position are not counted.
- R6: An interval longer than 255 clocks reads 0xFF, and an interval of exactly 255 clocks reads 0xFF.
- R7: All four intervals update together on the fourth rising clock edge after the data input rises for the fifth time. Until then, the registers keep their earlier values.
- R8: A line-start pulse that arrives before a capture completes leaves the results unchanged and sets the incomplete flag. The next completed capture clears the flag.
- R9: After the fifth edge the block stays idle. Further data edges change nothing, and the next line-start pulse does not set the incomplete flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; every count is in periods of this clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_start | input | 1 | One-clock pulse marking the start of a video line |
| data_in | input | 1 | Sliced video data bit, asynchronous to clk |
| reg_sel | input | 2 | Register select: 0 pair low, 1 pair high, 2 start position, 3 status |
| reg_wr | input | 1 | Write strobe, effective only with select 2 |
| reg_wdata | input | 11 | Start position write data |
| reg_rdata | output | 16 | Read data for the selected register (combinational) |

## Verification
The input path has a fixed latency: two synchronizer flops, one registered edge flop and one result flop. So a new result set becomes readable after the fourth clock edge that follows the fifth data rise. The bench drives data on falling clock edges. It reads the low-pair register after three clock edges, where it expects the previous value, and again after the fourth, where it expects the new one. Every edge passes through the same pipeline, so the latency cancels out and each interval is expected to equal the exact spacing the bench put between rises. The other checks wait well past the final edge before reading. The incomplete flag is read one clock edge after the line-start pulse.

// File: rtl/runin_pkg.sv
// Package: shared state encoding and register select codes for the
// clock run-in period monitor.
package runin_pkg;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_WAIT_POS = 2'd1,
        ST_ARMED    = 2'd2,
        ST_MEAS     = 2'd3
    } cap_state_t;

    localparam logic [1:0] SEL_PAIR_LO = 2'd0;
    localparam logic [1:0] SEL_PAIR_HI = 2'd1;
    localparam logic [1:0] SEL_START   = 2'd2;
    localparam logic [1:0] SEL_STATUS  = 2'd3;

endpackage

// File: rtl/runin_edge_sync.sv
// Synchronizes the asynchronous data bit with a flop chain and emits a
// registered one-clock pulse for each rising edge.
// Assumes SYNC_STAGES >= 2. Every edge sees the same latency.
module runin_edge_sync #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic data_in,
    output logic rise_q
);
    localparam int unsigned MSB = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   last_q;

    // Shift the input through the synchronizer and register the rise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            last_q <= 1'b0;
            rise_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], data_in};
            last_q <= sync_q[MSB];
            rise_q <= sync_q[MSB] & ~last_q;
        end
    end
endmodule

// File: rtl/runin_line_timer.sv
// Counts clocks from the most recent line-start pulse and flags the
// cycle in which the count equals the programmed start position.
// The count saturates at all ones, so long lines do not wrap.
module runin_line_timer #(
    parameter int unsigned POS_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_start,
    input  logic [POS_W-1:0] start_pos,
    output logic             pos_hit
);
    logic [POS_W-1:0] line_cnt_q;

    // Clear on line start, otherwise count up to saturation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_cnt_q <= '1;
        end else if (line_start) begin
            line_cnt_q <= '0;
        end else if (line_cnt_q != '1) begin
            line_cnt_q <= line_cnt_q + 1'b1;
        end
    end

    // Window-open compare.
    always_comb pos_hit = (line_cnt_q == start_pos);
endmodule

// File: rtl/runin_interval_meas.sv
// Capture sequencer: waits for the start position, then times NUM_INT
// consecutive edge-to-edge gaps with a saturating counter. All results
// are committed together on the final edge. A line start that arrives
// mid-capture leaves the results as they are and raises the incomplete flag.
// Assumes rise is a one-clock pulse per synchronized rising edge.
module runin_interval_meas
    import runin_pkg::*;
#(
    parameter int unsigned CNT_W   = 8,
    parameter int unsigned NUM_INT = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     line_start,
    input  logic                     pos_hit,
    input  logic                     rise,
    output logic [NUM_INT*CNT_W-1:0] res_flat,
    output logic                     incomplete,
    output logic                     commit,
    output cap_state_t               state
);
    localparam int unsigned IDX_W = (NUM_INT > 2) ? $clog2(NUM_INT) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_INT - 1);

    cap_state_t                           state_q;
    logic [IDX_W-1:0]                     idx_q;
    logic [CNT_W-1:0]                     per_cnt_q;
    logic [NUM_INT-2:0][CNT_W-1:0]        shadow_q;
    logic [NUM_INT-1:0][CNT_W-1:0]        res_q;
    logic                                 incomplete_q;

    // Final-edge detect, used for the commit.
    always_comb commit = !line_start && (state_q == ST_MEAS) && rise && (idx_q == LAST_IDX);

    // Sequencer, gap counter, shadow capture and result commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q      <= ST_IDLE;
            idx_q        <= '0;
            per_cnt_q    <= '0;
            shadow_q     <= '0;
            res_q        <= '0;
            incomplete_q <= 1'b0;
        end else if (line_start) begin
            state_q <= ST_WAIT_POS;
            idx_q   <= '0;
            if (state_q != ST_IDLE) begin
                incomplete_q <= 1'b1;
            end
        end else begin
            case (state_q)
                ST_WAIT_POS: begin
                    if (pos_hit) begin
                        state_q <= ST_ARMED;
                    end
                end
                ST_ARMED: begin
                    if (rise) begin
                        state_q   <= ST_MEAS;
                        per_cnt_q <= CNT_W'(1);
                        idx_q     <= '0;
                    end
                end
                ST_MEAS: begin
                    if (rise) begin
                        per_cnt_q <= CNT_W'(1);
                        if (idx_q == LAST_IDX) begin
                            res_q        <= {per_cnt_q, shadow_q};
                            incomplete_q <= 1'b0;
                            state_q      <= ST_IDLE;
                        end else begin
                            shadow_q[idx_q] <= per_cnt_q;
                            idx_q           <= idx_q + 1'b1;
                        end
                    end else if (per_cnt_q != '1) begin
                        per_cnt_q <= per_cnt_q + 1'b1;
                    end
                end
                default: begin
                    state_q <= ST_IDLE;
                end
            endcase
        end
    end

    // Outputs.
    always_comb begin
        res_flat   = res_q;
        incomplete = incomplete_q;
        state      = state_q;
    end
endmodule

// File: rtl/runin_regs.sv
// Register port: holds the writable start position and multiplexes the
// result pairs, start position and status onto the read data.
// Assumes NUM_INT*CNT_W == 2*REG_W, so the results fill two pair registers.
module runin_regs
    import runin_pkg::*;
#(
    parameter int unsigned POS_W   = 11,
    parameter int unsigned CNT_W   = 8,
    parameter int unsigned NUM_INT = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [1:0]               reg_sel,
    input  logic                     reg_wr,
    input  logic [POS_W-1:0]         reg_wdata,
    input  logic [NUM_INT*CNT_W-1:0] res_flat,
    input  logic                     incomplete,
    output logic [POS_W-1:0]         start_pos,
    output logic [2*CNT_W-1:0]       reg_rdata
);
    localparam int unsigned REG_W = 2 * CNT_W;

    logic [POS_W-1:0] start_pos_q;

    // Start position register, loaded only through its own select.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_pos_q <= '1;
        end else if (reg_wr && (reg_sel == SEL_START)) begin
            start_pos_q <= reg_wdata;
        end
    end

    // Read multiplexer.
    always_comb begin
        case (reg_sel)
            SEL_PAIR_LO: reg_rdata = res_flat[REG_W-1:0];
            SEL_PAIR_HI: reg_rdata = res_flat[2*REG_W-1:REG_W];
            SEL_START:   reg_rdata = {{(REG_W-POS_W){1'b0}}, start_pos_q};
            default:     reg_rdata = {{(REG_W-1){1'b0}}, incomplete};
        endcase
    end

    always_comb start_pos = start_pos_q;
endmodule

// File: rtl/runin_period_mon.sv
// Top of the clock run-in period monitor: edge synchronizer, line timer,
// capture sequencer and register port.
// Assumes line_start is a single-clock pulse in the clk domain.
module runin_period_mon
    import runin_pkg::*;
#(
    parameter int unsigned POS_W       = 11,
    parameter int unsigned CNT_W       = 8,
    parameter int unsigned NUM_INT     = 4,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_start,
    input  logic             data_in,
    input  logic [1:0]       reg_sel,
    input  logic             reg_wr,
    input  logic [POS_W-1:0] reg_wdata,
    output logic [15:0]      reg_rdata
);
    logic                     rise_evt;
    logic                     pos_hit;
    logic [POS_W-1:0]         start_pos;
    logic [NUM_INT*CNT_W-1:0] res_flat;
    logic                     incomplete;
    logic                     commit_evt;
    cap_state_t               cap_state;

    runin_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .data_in (data_in),
        .rise_q  (rise_evt)
    );

    runin_line_timer #(.POS_W(POS_W)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_start (line_start),
        .start_pos  (start_pos),
        .pos_hit    (pos_hit)
    );

    runin_interval_meas #(.CNT_W(CNT_W), .NUM_INT(NUM_INT)) u_meas (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_start (line_start),
        .pos_hit    (pos_hit),
        .rise       (rise_evt),
        .res_flat   (res_flat),
        .incomplete (incomplete),
        .commit     (commit_evt),
        .state      (cap_state)
    );

    runin_regs #(.POS_W(POS_W), .CNT_W(CNT_W), .NUM_INT(NUM_INT)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_sel    (reg_sel),
        .reg_wr     (reg_wr),
        .reg_wdata  (reg_wdata),
        .res_flat   (res_flat),
        .incomplete (incomplete),
        .start_pos  (start_pos),
        .reg_rdata  (reg_rdata)
    );
endmodule

// File: rtl/runin_period_mon_chk.sv
// Checker for the run-in period monitor, bound to the top module.
// It watches the top ports and the signals passed between submodules.
module runin_period_mon_chk
    import runin_pkg::*;
#(
    parameter int unsigned POS_W   = 11,
    parameter int unsigned CNT_W   = 8,
    parameter int unsigned NUM_INT = 4
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     line_start,
    input logic [1:0]               reg_sel,
    input logic [15:0]              reg_rdata,
    input logic [POS_W-1:0]         start_pos,
    input logic [NUM_INT*CNT_W-1:0] res_flat,
    input logic                     rise_evt,
    input logic                     incomplete,
    input logic                     commit_evt,
    input cap_state_t               cap_state
);
    // R1: reset clears the results and flag and loads the full-scale start position.
    p_reset_values_r1: assert property (@(posedge clk)
        !rst_n |=> (res_flat == '0) && (start_pos == '1) && !incomplete);

    // R2: the start position select never drives the upper read bits.
    p_start_upper_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_sel == SEL_START) |-> (reg_rdata[15:POS_W] == '0));

    // R7: results change only in the clock after a registered edge.
    p_res_after_edge_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(res_flat) |-> $past(rise_evt));

    // R8: the incomplete flag rises only after a line-start pulse.
    p_incomplete_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(incomplete) |-> $past(line_start));

    // R9: the sequencer idles after a completed capture.
    p_idle_after_commit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        commit_evt |=> (cap_state == ST_IDLE));
endmodule

bind runin_period_mon runin_period_mon_chk #(
    .POS_W(POS_W), .CNT_W(CNT_W), .NUM_INT(NUM_INT)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .line_start (line_start),
    .reg_sel    (reg_sel),
    .reg_rdata  (reg_rdata),
    .start_pos  (start_pos),
    .res_flat   (res_flat),
    .rise_evt   (rise_evt),
    .incomplete (incomplete),
    .commit_evt (commit_evt),
    .cap_state  (cap_state)
);

// File: tb/tb_runin_period_mon.sv
// Scoreboard bench: the line driver pushes the result set it expects for
// each completed capture, and the monitor task pops and compares it.
module tb_runin_period_mon;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        line_start = 1'b0;
    logic        data_in = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic        reg_wr = 1'b0;
    logic [10:0] reg_wdata = '0;
    logic [15:0] reg_rdata;

    typedef struct packed {
        logic [15:0] lo;
        logic [15:0] hi;
        logic        stat;
    } exp_t;

    exp_t        exp_q[$];
    logic [15:0] cur_lo = 16'h0000;
    logic [15:0] cur_hi = 16'h0000;
    int          n_cmp = 0;
    int          n_bad = 0;

    always #5 clk = ~clk;

    runin_period_mon dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_start (line_start),
        .data_in    (data_in),
        .reg_sel    (reg_sel),
        .reg_wr     (reg_wr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata)
    );

    task automatic chk(input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Read without consuming a clock; called just after a falling edge.
    task automatic rd_now(input logic [1:0] s, output logic [15:0] v);
        reg_sel = s;
        #1 v = reg_rdata;
    endtask

    task automatic wr(input logic [1:0] s, input logic [10:0] d);
        @(negedge clk);
        reg_sel = s; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic line_begin();
        @(negedge clk);
        line_start = 1'b1;
        @(negedge clk);
        line_start = 1'b0;
    endtask

    function automatic logic [7:0] sat8(input int g);
        return (g > 255) ? 8'hFF : 8'(g);
    endfunction

    // Driver: n rises after first_delay, spaced by the given gaps. For a
    // full capture, push the expected set and check R7 timing at the final rise.
    task automatic send_rises(input int first_delay, input int g0, input int g1,
                              input int g2, input int g3, input int n, input bit full);
        int   gaps[4];
        logic [15:0] v;
        exp_t e;
        gaps = '{g0, g1, g2, g3};
        if (full) begin
            e.lo = {sat8(g1), sat8(g0)};
            e.hi = {sat8(g3), sat8(g2)};
            e.stat = 1'b0;
            exp_q.push_back(e);
        end
        repeat (first_delay) @(negedge clk);
        for (int k = 0; k < n; k++) begin
            data_in = 1'b1;
            if (full && k == n - 1) begin
                repeat (3) @(negedge clk);
                rd_now(2'd0, v);
                chk("R7", "pair low before 4th clock", v, cur_lo);
                @(negedge clk);
                rd_now(2'd0, v);
                chk("R7", "pair low at 4th clock", v, e.lo);
                data_in = 1'b0;
                cur_lo = e.lo;
                cur_hi = e.hi;
            end else begin
                repeat (2) @(negedge clk);
                data_in = 1'b0;
                if (k < n - 1) repeat (gaps[k] - 2) @(negedge clk);
            end
        end
        repeat (10) @(negedge clk);
    endtask

    // Monitor: pop the oldest expected set and compare it with the registers.
    task automatic score(input string req);
        exp_t        e;
        logic [15:0] v;
        if (exp_q.size() == 0) begin
            chk(req, "scoreboard empty", 16'h0001, 16'h0000);
            return;
        end
        e = exp_q.pop_front();
        @(negedge clk);
        rd_now(2'd0, v); chk(req, "pair low", v, e.lo);
        rd_now(2'd1, v); chk(req, "pair high", v, e.hi);
        rd_now(2'd3, v); chk(req, "status", v, {15'd0, e.stat});
    endtask

    initial begin
        #(200000 * 10);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [15:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd_now(2'd0, v); chk("R1", "pair low reset", v, 16'h0000);
        rd_now(2'd1, v); chk("R1", "pair high reset", v, 16'h0000);
        rd_now(2'd2, v); chk("R1", "start reset", v, 16'h07FF);
        rd_now(2'd3, v); chk("R1", "status reset", v, 16'h0000);

        // R2/R3 start position write, upper bits zero
        wr(2'd2, 11'd40);
        rd_now(2'd2, v); chk("R2", "start readback", v, 16'h0028);
        wr(2'd0, 11'h5A5); wr(2'd1, 11'h3C3); wr(2'd3, 11'h7FF);
        rd_now(2'd0, v); chk("R3", "pair low after write", v, 16'h0000);
        rd_now(2'd1, v); chk("R3", "pair high after write", v, 16'h0000);
        rd_now(2'd3, v); chk("R3", "status after write", v, 16'h0000);
        rd_now(2'd2, v); chk("R3", "start kept", v, 16'h0028);

        // R4/R5: an early pulse before the window, then four distinct gaps
        line_begin();
        repeat (10) @(negedge clk);
        data_in = 1'b1; repeat (2) @(negedge clk); data_in = 1'b0;
        send_rises(60, 8, 9, 10, 11, 5, 1'b1);
        score("R4 R5");

        // R6 saturation at 254, 255, 256
        line_begin();
        send_rises(60, 254, 255, 256, 5, 5, 1'b1);
        score("R6");

        // R8 short line: three rises then a new line start
        line_begin();
        send_rises(60, 10, 10, 10, 10, 3, 1'b0);
        line_begin();
        rd_now(2'd3, v); chk("R8", "incomplete set", v, 16'h0001);
        rd_now(2'd0, v); chk("R8", "pair low held", v, cur_lo);
        rd_now(2'd1, v); chk("R8", "pair high held", v, cur_hi);
        send_rises(60, 30, 12, 40, 6, 5, 1'b1);
        score("R8");

        // R9 rises after completion are ignored, next line start sets no flag
        send_rises(10, 5, 5, 5, 5, 5, 1'b0);
        @(negedge clk);
        rd_now(2'd0, v); chk("R9", "pair low unchanged", v, cur_lo);
        rd_now(2'd1, v); chk("R9", "pair high unchanged", v, cur_hi);
        wr(2'd2, 11'd0);
        line_begin();
        rd_now(2'd3, v); chk("R9", "no incomplete after idle", v, 16'h0000);

        // R4 start position zero, another gap pattern
        send_rises(10, 4, 100, 17, 64, 5, 1'b1);
        score("R4");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule